// File: doc/BRIEF.md
# Host Port Handshake Status Logic

This block keeps the handshake state for a 32-bit data port that runs in both directions between an external host processor and a DSP core. Each direction has two registers in series. A host write fills a host-side transmit register, and that word later moves into a core-side receive register. A core write fills a core-side transmit register, and that word later moves into a host-side receive register. A word moves forward when its source register is loaded and its destination register is empty. The core sees the state of both paths as a 32-bit read-only status word. The host cannot read that word.

The block also holds a host-command pending flag, two flags that only the host can change, and a set of core-owned enable bits. Each enable bit gates one pending condition into a registered, level-sensitive interrupt request. Reset comes from three sources: an asynchronous hardware reset, a synchronous software reset, and a host-side reset. An init strobe carries two qualifiers, and each qualifier flushes one direction. The core's exception unit is represented by a single strobe that marks the fetch of the second vector word of the host-command interrupt.

Each direction is a four-state machine over the occupancy of its two registers. The states are `PIPE_EMPTY` (both registers free), `PIPE_HELD` (only the source register holds a word), `PIPE_READY` (only the destination register holds a word) and `PIPE_FULL` (both hold words). The transitions are as follows:
- EMPTY→HELD on a source write.
- HELD→READY on a transfer.
- HELD→FULL on a transfer with a source write in the same cycle.
- HELD→HELD when the core's access stalls the transfer.
- READY→EMPTY on a destination read.
- READY→FULL on a source write.
- READY→HELD on a read and a write in the same cycle.
- FULL→HELD on a destination read.
- Any state→EMPTY on that direction's flush.

Top module: `hostport_status`

## Requirements
- R1: After hardware reset, the status word reads 0x0000_0002 (only bit 1, transmit-empty, is set). All interrupt requests are 0 and all enable bits are 0.
- R2: A host write into the host transmit register sets status bit 0 (receive-full) two clock edges later, and the word appears on `core_rx_data`. A core read while bit 0 is set clears bit 0 at the next edge.
- R3: A second host word waits in the host transmit register while the core receive register is full. It moves in on the edge after the core read, so bit 0 reads 0 for exactly one cycle.
- R4: A core write clears status bit 1 at the next edge. The word moves into the host receive register one edge later if that register is empty, and bit 1 then sets again.
- R5: While the host receive register is full, bit 1 stays 0. The pending core word moves on the edge after a host read.
- R6: Init with the transmit-request qualifier empties the host-to-core path (bit 0 → 0). Init with the receive-request qualifier empties the core-to-host path (bit 1 → 1, host receive register empty). Init with neither qualifier changes nothing.
- R7: Host reset clears bit 0, forces bit 1 to 1 and empties both paths. The host flags and the command flag are left unchanged.
- R8: Software reset has the same effect as hardware reset on the status word, the enable bits and the interrupt requests.
- R9: Status bit 2 (command pending) sets on the edge after the host sets the command bit. It clears on the edge after the second-vector-fetch strobe. When both arrive in the same cycle, the host's set wins.
- R10: Status bits 4:3 show the two host flags, loaded from `host_flag_val[1:0]` on a host flag write.
- R11: Interrupt request index i (0 receive-full, 1 transmit-empty, 2 command pending, 3 host memory read pending, 4 host memory write pending) equals, one edge late, its pending condition ANDed with enable bit i of `core_ctl_en`.
- R12: The core has priority over a transfer. A core read and a core write in the same cycle both take effect. A core write during a pending core-to-host transfer replaces the word and delays the transfer by one edge. A core read during a pending host-to-core transfer delays that transfer by one edge.
- R13: Status bits 31:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| host_rst | input | 1 | Synchronous host-side reset of both data paths |
| host_tx_wr | input | 1 | Host writes its transmit register |
| host_tx_data | input | 32 | Host transmit word |
| host_tx_full | output | 1 | Host transmit register holds an unsent word |
| host_rx_rd | input | 1 | Host reads its receive register |
| host_rx_data | output | 32 | Host receive word |
| host_rx_full | output | 1 | Host receive register holds a word |
| host_cmd_set | input | 1 | Host sets the command bit |
| host_flag_wr | input | 1 | Host writes its two general flags |
| host_flag_val | input | 2 | New host flag values |
| mem_rd_pend | input | 1 | Host memory read command pending |
| mem_wr_pend | input | 1 | Host memory write command pending |
| init_req | input | 1 | Init strobe |
| init_treq | input | 1 | Init qualifier: flush host-to-core path |
| init_rreq | input | 1 | Init qualifier: flush core-to-host path |
| core_rx_rd | input | 1 | Core reads its receive register |
| core_rx_data | output | 32 | Core receive word |
| core_tx_wr | input | 1 | Core writes its transmit register |
| core_tx_data | input | 32 | Core transmit word |
| core_ctl_wr | input | 1 | Core loads the interrupt enable bits |
| core_ctl_en | input | 5 | New enable bits, same index as the requests |
| vec2_fetch | input | 1 | Exception unit fetched the second host-command vector word |
| status_o | output | 32 | Read-only status word for the core |
| irq_o | output | 5 | Registered interrupt requests |

## Verification
The bench targets the one-cycle gap in receive-full when a queued host word follows a core read. A design that transferred in the same cycle as the read would never show that gap. Other such designs would lose the second word. The core-write stall during a pending transfer is checked by data value: a design that ignored the core's priority would deliver the older word to the host. The two init qualifiers are applied separately and together with neither. A design that shared one flush between the directions would clear the wrong flag, and a design that reset transmit-empty to 0 would report a full register after init or reset. The bench also checks that a set and a clear of the command bit in the same cycle leave it pending, and that an interrupt appears exactly one edge after its enable is written.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [1:0] {
        PIPE_EMPTY = 2'b00,
        PIPE_HELD  = 2'b01,
        PIPE_READY = 2'b10,
        PIPE_FULL  = 2'b11
    } pipe_state_t;

    localparam int IRQ_RXF   = 0;
    localparam int IRQ_TXE   = 1;
    localparam int IRQ_CMD   = 2;
    localparam int IRQ_MRD   = 3;
    localparam int IRQ_MWR   = 4;
    localparam int NUM_IRQ   = 5;

    localparam int ST_RXF    = 0;
    localparam int ST_TXE    = 1;
    localparam int ST_CMD    = 2;
    localparam int ST_FLAG_LO = 3;
    localparam int NUM_HFLAG = 2;

endpackage

// File: rtl/hps_pipe.sv
module hps_pipe
    import hps_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              src_wr,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dst_rd,
    input  logic              stall,
    output logic              src_full,
    output logic              dst_full,
    output logic [DATA_W-1:0] dst_data
);

    pipe_state_t       st_q;
    pipe_state_t       st_d;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] dst_q;
    logic              move;

    assign move = (st_q == PIPE_HELD) && !stall && !flush;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIPE_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIPE_EMPTY: st_d = src_wr ? PIPE_HELD : PIPE_EMPTY;
            PIPE_HELD: begin
                if (stall)       st_d = PIPE_HELD;
                else if (src_wr) st_d = PIPE_FULL;
                else             st_d = PIPE_READY;
            end
            PIPE_READY: begin
                unique case ({src_wr, dst_rd})
                    2'b00: st_d = PIPE_READY;
                    2'b01: st_d = PIPE_EMPTY;
                    2'b10: st_d = PIPE_FULL;
                    2'b11: st_d = PIPE_HELD;
                    default: st_d = PIPE_READY;
                endcase
            end
            PIPE_FULL: st_d = dst_rd ? PIPE_HELD : PIPE_FULL;
            default: st_d = PIPE_EMPTY;
        endcase
        if (flush) st_d = PIPE_EMPTY;
    end

    // outputs
    always_comb begin
        src_full = 1'b0;
        dst_full = 1'b0;
        unique case (st_q)
            PIPE_EMPTY: begin src_full = 1'b0; dst_full = 1'b0; end
            PIPE_HELD:  begin src_full = 1'b1; dst_full = 1'b0; end
            PIPE_READY: begin src_full = 1'b0; dst_full = 1'b1; end
            PIPE_FULL:  begin src_full = 1'b1; dst_full = 1'b1; end
            default:    begin src_full = 1'b0; dst_full = 1'b0; end
        endcase
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (src_wr) src_q <= src_data;
            if (move)   dst_q <= src_q;
        end
    end

    assign dst_data = dst_q;

endmodule

// File: rtl/hps_cmd_flags.sv
module hps_cmd_flags
    import hps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 cmd_set,
    input  logic                 cmd_served,
    input  logic                 flag_wr,
    input  logic [NUM_HFLAG-1:0] flag_val,
    output logic                 cmd_pend,
    output logic [NUM_HFLAG-1:0] flags
);

    logic                 cmd_q;
    logic [NUM_HFLAG-1:0] flag_q;

    // a newly issued command survives a same-cycle vector fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cmd_q <= 1'b0;
        else if (soft_rst)   cmd_q <= 1'b0;
        else if (cmd_set)    cmd_q <= 1'b1;
        else if (cmd_served) cmd_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= '0;
        else if (soft_rst) flag_q <= '0;
        else if (flag_wr)  flag_q <= flag_val;
    end

    assign cmd_pend = cmd_q;
    assign flags    = flag_q;

endmodule

// File: rtl/hps_irq_gate.sv
module hps_irq_gate #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] pend,
    input  logic         en_wr,
    input  logic [N-1:0] en_val,
    output logic [N-1:0] en_q,
    output logic [N-1:0] irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        en_q <= '0;
        else if (soft_rst) en_q <= '0;
        else if (en_wr)    en_q <= en_val;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic req_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        req_q <= 1'b0;
            else if (soft_rst) req_q <= 1'b0;
            else               req_q <= pend[i] & en_q[i];
        end
        assign irq[i] = req_q;
    end

endmodule

// File: rtl/hostport_status.sv
module hostport_status
    import hps_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 host_rst,
    input  logic                 host_tx_wr,
    input  logic [DATA_W-1:0]    host_tx_data,
    output logic                 host_tx_full,
    input  logic                 host_rx_rd,
    output logic [DATA_W-1:0]    host_rx_data,
    output logic                 host_rx_full,
    input  logic                 host_cmd_set,
    input  logic                 host_flag_wr,
    input  logic [NUM_HFLAG-1:0] host_flag_val,
    input  logic                 mem_rd_pend,
    input  logic                 mem_wr_pend,
    input  logic                 init_req,
    input  logic                 init_treq,
    input  logic                 init_rreq,
    input  logic                 core_rx_rd,
    output logic [DATA_W-1:0]    core_rx_data,
    input  logic                 core_tx_wr,
    input  logic [DATA_W-1:0]    core_tx_data,
    input  logic                 core_ctl_wr,
    input  logic [NUM_IRQ-1:0]   core_ctl_en,
    input  logic                 vec2_fetch,
    output logic [STAT_W-1:0]    status_o,
    output logic [NUM_IRQ-1:0]   irq_o
);

    localparam int FLAG_HI = ST_FLAG_LO + NUM_HFLAG - 1;

    logic                 flush_h2c;
    logic                 flush_c2h;
    logic                 core_rx_full;
    logic                 core_tx_full;
    logic                 cmd_pend;
    logic [NUM_HFLAG-1:0] hflags;
    logic [NUM_IRQ-1:0]   pend;
    logic [NUM_IRQ-1:0]   ctl_en;

    assign flush_h2c = soft_rst | host_rst | (init_req & init_treq);
    assign flush_c2h = soft_rst | host_rst | (init_req & init_rreq);

    hps_pipe #(.DATA_W(DATA_W)) u_h2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_h2c),
        .src_wr   (host_tx_wr),
        .src_data (host_tx_data),
        .dst_rd   (core_rx_rd),
        .stall    (core_rx_rd),
        .src_full (host_tx_full),
        .dst_full (core_rx_full),
        .dst_data (core_rx_data)
    );

    hps_pipe #(.DATA_W(DATA_W)) u_c2h (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_c2h),
        .src_wr   (core_tx_wr),
        .src_data (core_tx_data),
        .dst_rd   (host_rx_rd),
        .stall    (core_tx_wr),
        .src_full (core_tx_full),
        .dst_full (host_rx_full),
        .dst_data (host_rx_data)
    );

    hps_cmd_flags u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .cmd_set    (host_cmd_set),
        .cmd_served (vec2_fetch),
        .flag_wr    (host_flag_wr),
        .flag_val   (host_flag_val),
        .cmd_pend   (cmd_pend),
        .flags      (hflags)
    );

    always_comb begin
        pend          = '0;
        pend[IRQ_RXF] = core_rx_full;
        pend[IRQ_TXE] = !core_tx_full;
        pend[IRQ_CMD] = cmd_pend;
        pend[IRQ_MRD] = mem_rd_pend;
        pend[IRQ_MWR] = mem_wr_pend;
    end

    hps_irq_gate #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .pend     (pend),
        .en_wr    (core_ctl_wr),
        .en_val   (core_ctl_en),
        .en_q     (ctl_en),
        .irq      (irq_o)
    );

    always_comb begin
        status_o                    = '0;
        status_o[ST_RXF]            = core_rx_full;
        status_o[ST_TXE]            = !core_tx_full;
        status_o[ST_CMD]            = cmd_pend;
        status_o[FLAG_HI:ST_FLAG_LO] = hflags;
    end

endmodule

// File: rtl/hps_checker.sv
module hps_checker
    import hps_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 host_rst,
    input logic                 host_cmd_set,
    input logic                 host_flag_wr,
    input logic [NUM_HFLAG-1:0] host_flag_val,
    input logic                 mem_rd_pend,
    input logic                 mem_wr_pend,
    input logic                 init_req,
    input logic                 init_treq,
    input logic                 init_rreq,
    input logic                 core_rx_rd,
    input logic                 core_tx_wr,
    input logic                 vec2_fetch,
    input logic [NUM_IRQ-1:0]   ctl_en,
    input logic [31:0]          status_o,
    input logic [NUM_IRQ-1:0]   irq_o
);

    logic [NUM_IRQ-1:0] pend_view;
    assign pend_view = {mem_wr_pend, mem_rd_pend, status_o[2], status_o[1], status_o[0]};

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_rx_rd && status_o[0] |=> !status_o[0]);

    assert_write_drops_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_wr && !soft_rst && !host_rst && !(init_req && init_rreq) |=> !status_o[1]);

    assert_init_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_req && init_treq |=> !status_o[0]);

    assert_init_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_req && init_rreq |=> status_o[1]);

    assert_host_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> !status_o[0] && status_o[1]);

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_o == 32'h2) && (irq_o == '0));

    assert_cmd_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_cmd_set && !soft_rst |=> status_o[2]);

    assert_cmd_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec2_fetch && !host_cmd_set |=> !status_o[2]);

    assert_host_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_flag_wr && !soft_rst |=> status_o[4:3] == $past(host_flag_val));

    assert_irq_gating_R11: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !$past(soft_rst) |-> irq_o == $past(pend_view & ctl_en));

    assert_spare_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[31:5] == '0);

endmodule

bind hostport_status hps_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .host_rst      (host_rst),
    .host_cmd_set  (host_cmd_set),
    .host_flag_wr  (host_flag_wr),
    .host_flag_val (host_flag_val),
    .mem_rd_pend   (mem_rd_pend),
    .mem_wr_pend   (mem_wr_pend),
    .init_req      (init_req),
    .init_treq     (init_treq),
    .init_rreq     (init_rreq),
    .core_rx_rd    (core_rx_rd),
    .core_tx_wr    (core_tx_wr),
    .vec2_fetch    (vec2_fetch),
    .ctl_en        (ctl_en),
    .status_o      (status_o),
    .irq_o         (irq_o)
);

// File: tb/sim_hostport_status.sv
`timescale 1ns/1ps
module sim_hostport_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        host_rst = 1'b0;
    logic        host_tx_wr = 1'b0;
    logic [31:0] host_tx_data = '0;
    logic        host_tx_full;
    logic        host_rx_rd = 1'b0;
    logic [31:0] host_rx_data;
    logic        host_rx_full;
    logic        host_cmd_set = 1'b0;
    logic        host_flag_wr = 1'b0;
    logic [1:0]  host_flag_val = '0;
    logic        mem_rd_pend = 1'b0;
    logic        mem_wr_pend = 1'b0;
    logic        init_req = 1'b0;
    logic        init_treq = 1'b0;
    logic        init_rreq = 1'b0;
    logic        core_rx_rd = 1'b0;
    logic [31:0] core_rx_data;
    logic        core_tx_wr = 1'b0;
    logic [31:0] core_tx_data = '0;
    logic        core_ctl_wr = 1'b0;
    logic [4:0]  core_ctl_en = '0;
    logic        vec2_fetch = 1'b0;
    logic [31:0] status_o;
    logic [4:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hostport_status u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_rst(host_rst),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data), .host_tx_full(host_tx_full),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data), .host_rx_full(host_rx_full),
        .host_cmd_set(host_cmd_set), .host_flag_wr(host_flag_wr), .host_flag_val(host_flag_val),
        .mem_rd_pend(mem_rd_pend), .mem_wr_pend(mem_wr_pend),
        .init_req(init_req), .init_treq(init_treq), .init_rreq(init_rreq),
        .core_rx_rd(core_rx_rd), .core_rx_data(core_rx_data),
        .core_tx_wr(core_tx_wr), .core_tx_data(core_tx_data),
        .core_ctl_wr(core_ctl_wr), .core_ctl_en(core_ctl_en),
        .vec2_fetch(vec2_fetch), .status_o(status_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic host_send(input logic [31:0] d);
        host_tx_wr = 1'b1; host_tx_data = d; tick(); host_tx_wr = 1'b0;
    endtask

    task automatic core_send(input logic [31:0] d);
        core_tx_wr = 1'b1; core_tx_data = d; tick(); core_tx_wr = 1'b0;
    endtask

    task automatic core_read();
        core_rx_rd = 1'b1; tick(); core_rx_rd = 1'b0;
    endtask

    task automatic host_read();
        host_rx_rd = 1'b1; tick(); host_rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 32'h2);
        chk("R1 irq", {27'd0, irq_o}, 32'h0);
        chk("R13 spare bits", {5'd0, status_o[31:5]}, 32'h0);
    endtask

    task automatic t_h2c();
        host_send(32'hA5A5_0001);
        chk("R2 rxf before move", {31'd0, status_o[0]}, 32'h0);
        tick();
        chk("R2 rxf set", {31'd0, status_o[0]}, 32'h1);
        chk("R2 rx data", core_rx_data, 32'hA5A5_0001);
        core_read();
        chk("R2 rxf cleared", {31'd0, status_o[0]}, 32'h0);
    endtask

    task automatic t_h2c_backlog();
        host_send(32'h0000_00D1); tick();
        host_send(32'h0000_00D2); tick(); tick();
        chk("R3 first word held", core_rx_data, 32'h0000_00D1);
        chk("R3 second waits", {31'd0, host_tx_full}, 32'h1);
        core_read();
        chk("R3 gap cycle", {31'd0, status_o[0]}, 32'h0);
        tick();
        chk("R3 second arrives", {31'd0, status_o[0]}, 32'h1);
        chk("R3 second data", core_rx_data, 32'h0000_00D2);
        core_read();
    endtask

    task automatic t_c2h();
        core_send(32'h0000_00C1);
        chk("R4 txe dropped", {31'd0, status_o[1]}, 32'h0);
        tick();
        chk("R4 txe back", {31'd0, status_o[1]}, 32'h1);
        chk("R4 host data", host_rx_data, 32'h0000_00C1);
        host_read();
        chk("R4 host rx drained", {31'd0, host_rx_full}, 32'h0);
    endtask

    task automatic t_c2h_blocked();
        core_send(32'h0000_00C2); tick();
        core_send(32'h0000_00C3); tick(); tick();
        chk("R5 txe held low", {31'd0, status_o[1]}, 32'h0);
        chk("R5 old host data", host_rx_data, 32'h0000_00C2);
        host_read();
        chk("R5 txe still low", {31'd0, status_o[1]}, 32'h0);
        tick();
        chk("R5 txe set", {31'd0, status_o[1]}, 32'h1);
        chk("R5 new host data", host_rx_data, 32'h0000_00C3);
        host_read();
    endtask

    task automatic t_init();
        host_send(32'h1111_0000); tick();
        core_send(32'h2222_0000); tick();
        core_send(32'h3333_0000); tick();
        init_req = 1'b1; tick(); init_req = 1'b0;
        chk("R6 bare init", status_o[1:0], 32'h1);
        init_req = 1'b1; init_treq = 1'b1; tick(); init_req = 1'b0; init_treq = 1'b0;
        chk("R6 treq init", status_o[1:0], 32'h0);
        init_req = 1'b1; init_rreq = 1'b1; tick(); init_req = 1'b0; init_rreq = 1'b0;
        chk("R6 rreq init", status_o[1:0], 32'h2);
        chk("R6 host rx flushed", {31'd0, host_rx_full}, 32'h0);
    endtask

    task automatic t_host_rst();
        host_flag_wr = 1'b1; host_flag_val = 2'b11; tick(); host_flag_wr = 1'b0;
        host_send(32'h4444_0000); tick();
        core_send(32'h5555_0000); tick();
        core_send(32'h6666_0000); tick();
        host_rst = 1'b1; tick(); host_rst = 1'b0;
        chk("R7 status after host reset", status_o, 32'h1A);
        chk("R7 host rx empty", {31'd0, host_rx_full}, 32'h0);
    endtask

    task automatic t_soft_rst();
        host_cmd_set = 1'b1; tick(); host_cmd_set = 1'b0;
        core_ctl_wr = 1'b1; core_ctl_en = 5'h1F; tick(); core_ctl_wr = 1'b0;
        chk("R8 before soft reset", status_o, 32'h1E);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk("R8 status", status_o, 32'h2);
        chk("R8 irq", {27'd0, irq_o}, 32'h0);
        mem_rd_pend = 1'b1; tick(); tick();
        chk("R8 enables cleared", {27'd0, irq_o}, 32'h0);
        mem_rd_pend = 1'b0;
    endtask

    task automatic t_cmd();
        host_cmd_set = 1'b1; tick(); host_cmd_set = 1'b0;
        chk("R9 set", {31'd0, status_o[2]}, 32'h1);
        vec2_fetch = 1'b1; tick(); vec2_fetch = 1'b0;
        chk("R9 served", {31'd0, status_o[2]}, 32'h0);
        host_cmd_set = 1'b1; vec2_fetch = 1'b1; tick();
        host_cmd_set = 1'b0; vec2_fetch = 1'b0;
        chk("R9 set wins", {31'd0, status_o[2]}, 32'h1);
    endtask

    task automatic t_flags();
        host_flag_wr = 1'b1; host_flag_val = 2'b01; tick();
        chk("R10 flags 01", {30'd0, status_o[4:3]}, 32'h1);
        host_flag_val = 2'b10; tick(); host_flag_wr = 1'b0;
        chk("R10 flags 10", {30'd0, status_o[4:3]}, 32'h2);
        core_ctl_wr = 1'b1; core_ctl_en = 5'h1F; tick(); core_ctl_wr = 1'b0;
        chk("R10 core write no effect", {30'd0, status_o[4:3]}, 32'h2);
        core_ctl_wr = 1'b1; core_ctl_en = 5'h00; tick(); core_ctl_wr = 1'b0;
    endtask

    task automatic t_irq();
        tick();
        core_ctl_wr = 1'b1; core_ctl_en = 5'b00010; tick(); core_ctl_wr = 1'b0;
        chk("R11 one edge late", {27'd0, irq_o}, 32'h0);
        tick();
        chk("R11 txe request", {27'd0, irq_o}, 32'h2);
        mem_wr_pend = 1'b1; tick(); tick();
        chk("R11 masked memwr", {27'd0, irq_o}, 32'h2);
        core_ctl_wr = 1'b1; core_ctl_en = 5'h1F; tick(); core_ctl_wr = 1'b0; tick();
        chk("R11 all enabled", {27'd0, irq_o}, 32'h16);
        mem_wr_pend = 1'b0;
        vec2_fetch = 1'b1; tick(); vec2_fetch = 1'b0; tick();
        chk("R11 cmd withdrawn", {27'd0, irq_o}, 32'h2);
        core_ctl_wr = 1'b1; core_ctl_en = 5'h00; tick(); core_ctl_wr = 1'b0; tick();
    endtask

    task automatic t_priority();
        host_send(32'h0000_0E01); tick();
        core_rx_rd = 1'b1; core_tx_wr = 1'b1; core_tx_data = 32'h0000_0F01; tick();
        core_rx_rd = 1'b0; core_tx_wr = 1'b0;
        chk("R12 dual access", status_o[1:0], 32'h0);
        tick();
        chk("R12 host word", host_rx_data, 32'h0000_0F01);
        host_read();
        core_tx_wr = 1'b1; core_tx_data = 32'h0000_0F02; tick();
        core_tx_data = 32'h0000_0F03; tick(); core_tx_wr = 1'b0;
        chk("R12 write stalls move", {31'd0, status_o[1]}, 32'h0);
        tick();
        chk("R12 newer word delivered", host_rx_data, 32'h0000_0F03);
        host_read();
        host_send(32'h0000_0E02);
        core_read();
        chk("R12 read stalls move", {31'd0, status_o[0]}, 32'h0);
        tick();
        chk("R12 move after stall", {31'd0, status_o[0]}, 32'h1);
        core_read();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_h2c();
        t_h2c_backlog();
        t_c2h();
        t_c2h_blocked();
        t_init();
        t_host_rst();
        t_soft_rst();
        t_cmd();
        t_flags();
        t_irq();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule